// File: doc/BRIEF.md
# Serial Response Frame Receiver

This block collects one response frame from a slave on a two-wire serial link (clock driven by this side, one bidirectional active-low data wire). After the surrounding logic has sent a command, it pulses `start_i`. The block then releases its data driver, toggles the link clock, and samples one bit per link clock period while it hunts for the start bit. If no start bit arrives within a bounded number of periods, it stops and reports a timeout.

Once the start bit is seen, it takes in a slave identifier and a response tag. If the tag says the command was acknowledged and a read size was requested, it then takes in one, two or four data bytes. The frame ends with a four-bit check code. The block runs the check code over the whole frame, starting bit included, and flags any nonzero remainder. When it finishes it pulses `done_o` together with the result and the two error flags. What to do about a busy or error tag is left to the caller.

Top module: `resp_frame_rx`

## Requirements
- R1: During and straight after reset, `bclk_o` and `oe_o` are 1 and `done_o`, `timeout_o`, `crc_err_o`, `tag_o`, `id_o` and `rdata_o` are 0.
- R2: Each received bit takes two cycles of `bclk_o`: one low cycle, then one high cycle. `sdata_i` is sampled at the clock edge that ends the high cycle. The wire is active-low, so a wire level of 0 is logical 1.
- R3: `oe_o` drops to 0 in the cycle after `start_i` is accepted and stays 0 until the cycle in which `done_o` is 1, when `oe_o` and `bclk_o` both return to 1.
- R4: Up to HUNT_MAX (default 1000) bit periods are sampled while waiting for a logical-1 start bit. A start bit in the last of those periods is accepted. Otherwise the block ends with `timeout_o`=1, `crc_err_o`=0, and `tag_o`, `id_o`, `rdata_o` all 0.
- R5: The four bits after the start bit are, in order, the 2-bit slave ID and then the 2-bit tag, each MSB first. The tag codes are 0 acknowledge, 1 busy, 2 general error, and 3 slave-detected check error.
- R6: `size_i` is latched with `start_i`: code 0 means no data, 1 means one byte, 2 means two bytes, 3 means four bytes. Data bits follow the header only when the tag is 0 and the size code is nonzero. Otherwise the check code follows the header at once and `rdata_o` is 0.
- R7: Each data byte arrives MSB first. The first byte received lands in `rdata_o[7:0]`, the second in `[15:8]`, and so on. Bytes not received are 0.
- R8: The check code uses polynomial x^4+x+1, processed MSB first from a zero register. It covers the start bit, the header, the data and the 4 trailing check bits. A nonzero final remainder sets `crc_err_o`, while tag, ID and data are still reported.
- R9: `done_o` is a single-cycle pulse. The result outputs keep their values until the next `done_o`.
- R10: `start_i` has no effect while a frame is being received.
- R11: If S bits are sampled in total (including the hunting bits), `done_o` is 1 in the cycle that begins 2*S clock edges after the edge that accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin receiving one response frame |
| size_i | input | 2 | Expected read size code (0/1/2/3 = 0/1/2/4 bytes) |
| sdata_i | input | 1 | Data wire level, active-low |
| bclk_o | output | 1 | Link clock, high when idle |
| oe_o | output | 1 | Data-wire output enable, 0 while receiving |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | No start bit found within the hunt window |
| crc_err_o | output | 1 | Nonzero check remainder |
| tag_o | output | 2 | Received response tag |
| id_o | output | 2 | Received slave ID |
| rdata_o | output | 32 | Read data, first byte in bits 7:0 |

## Verification
On every cycle, the assertions check the link clock alternating while a frame is in progress and the single-cycle `done_o` pulse. They also check that results stay stable between completions, that the two error flags are never set together, that data is zero on any non-acknowledge or timeout result, and that the driver is restored at completion. The bench scenarios are the only place where the frame contents can be checked: byte order for each size, data being skipped on a busy tag, the exact edge of the hunt window, detection of a corrupted check code, end-to-end latency, and a repeated start having no effect.

// File: rtl/resp_frame_rx_pkg.sv
package resp_frame_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_HDR,
    ST_DATA,
    ST_CHK
  } rx_state_e;

  localparam logic [1:0] TAG_ACK  = 2'd0;
  localparam logic [1:0] TAG_BUSY = 2'd1;
  localparam int HDR_BITS = 4;
  localparam int CHK_BITS = 4;
endpackage

// File: rtl/resp_frame_bitclk.sv
module resp_frame_bitclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bclk_o,
  output logic stb_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= 1'b0;
    else if (!run_i) ph_q <= 1'b0;
    else             ph_q <= ~ph_q;
  end

  // low phase then high phase; sample at the edge closing the high phase
  assign bclk_o = ~run_i | ph_q;
  assign stb_o  = run_i & ph_q;

  AST_BCLK_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (bclk_o != $past(bclk_o))); // R2
endmodule

// File: rtl/resp_frame_crc4.sv
module resp_frame_crc4 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [3:0] crc_o,
  output logic [3:0] crc_next_o
);
  logic fb;

  assign fb         = crc_o[3] ^ bit_i;
  assign crc_next_o = {crc_o[2:0], 1'b0} ^ {2'b00, fb, fb};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= 4'd0;
    else if (clr_i) crc_o <= 4'd0;
    else if (en_i)  crc_o <= crc_next_o;
  end

  AST_CRC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == 4'd0)); // R8
endmodule

// File: rtl/resp_frame_unpack.sv
module resp_frame_unpack #(
  parameter int DATA_BYTES = 4,
  localparam int DW  = 8 * DATA_BYTES,
  localparam int NBW = $clog2(DATA_BYTES + 1)
) (
  input  logic [DW-1:0]  sh_i,
  input  logic [NBW-1:0] nb_i,
  output logic [DW-1:0]  data_o
);
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_byte
    logic [7:0]    byte_v;
    logic [DW-1:0] sft;
    always_comb begin
      sft    = '0;
      byte_v = 8'd0;
      if (k < int'(nb_i)) begin
        // first byte in sits highest in the shift register
        sft    = sh_i >> (8 * (int'(nb_i) - 1 - k));
        byte_v = sft[7:0];
      end
    end
    assign data_o[8*k +: 8] = byte_v;
  end
endmodule

// File: rtl/resp_frame_rx.sv
module resp_frame_rx
  import resp_frame_rx_pkg::*;
#(
  parameter int HUNT_MAX   = 1000,
  parameter int DATA_BYTES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [1:0]            size_i,
  input  logic                  sdata_i,
  output logic                  bclk_o,
  output logic                  oe_o,
  output logic                  done_o,
  output logic                  timeout_o,
  output logic                  crc_err_o,
  output logic [1:0]            tag_o,
  output logic [1:0]            id_o,
  output logic [8*DATA_BYTES-1:0] rdata_o
);
  localparam int DW   = 8 * DATA_BYTES;
  localparam int NBW  = $clog2(DATA_BYTES + 1);
  localparam int CMAX = (HUNT_MAX > DW) ? HUNT_MAX : DW;
  localparam int CW   = $clog2(CMAX + 1);

  rx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [3:0]     hdr_q;
  logic [DW-1:0]  dsh_q;
  logic [NBW-1:0] nb_q;
  logic [NBW-1:0] nb_req;
  logic [DW-1:0]  unpacked;
  logic [3:0]     crc_q, crc_nxt;
  logic           stb, rx_bit, run, clr;

  always_comb begin
    case (size_i)
      2'd1:    nb_req = NBW'(1);
      2'd2:    nb_req = NBW'(2);
      2'd3:    nb_req = NBW'(DATA_BYTES);
      default: nb_req = '0;
    endcase
  end

  assign run    = (state_q != ST_IDLE);
  assign clr    = (state_q == ST_IDLE) && start_i;
  assign rx_bit = ~sdata_i;
  assign oe_o   = ~run;

  resp_frame_bitclk u_bitclk (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run),
    .bclk_o(bclk_o), .stb_o (stb)
  );

  // zeros during the hunt leave a cleared register at zero, so the start bit seeds it
  resp_frame_crc4 u_crc (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr), .en_i (stb),
    .bit_i (rx_bit), .crc_o (crc_q), .crc_next_o (crc_nxt)
  );

  resp_frame_unpack #(.DATA_BYTES(DATA_BYTES)) u_unpack (
    .sh_i (dsh_q), .nb_i (nb_q), .data_o (unpacked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      dsh_q     <= '0;
      nb_q      <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      crc_err_o <= 1'b0;
      tag_o     <= '0;
      id_o      <= '0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_HUNT;
          cnt_q   <= '0;
          hdr_q   <= '0;
          dsh_q   <= '0;
          nb_q    <= nb_req;
        end
        ST_HUNT: if (stb) begin
          if (rx_bit) begin
            state_q <= ST_HDR;
            cnt_q   <= '0;
          end else if (cnt_q == CW'(HUNT_MAX - 1)) begin
            state_q   <= ST_IDLE;
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
            crc_err_o <= 1'b0;
            tag_o     <= '0;
            id_o      <= '0;
            rdata_o   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HDR: if (stb) begin
          hdr_q <= {hdr_q[2:0], rx_bit};
          if (cnt_q == CW'(HDR_BITS - 1)) begin
            cnt_q <= '0;
            if ({hdr_q[0], rx_bit} == TAG_ACK && nb_q != '0) state_q <= ST_DATA;
            else                                            state_q <= ST_CHK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: if (stb) begin
          dsh_q <= {dsh_q[DW-2:0], rx_bit};
          if (cnt_q == CW'({nb_q, 3'b000}) - 1'b1) begin
            state_q <= ST_CHK;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CHK: if (stb) begin
          if (cnt_q == CW'(CHK_BITS - 1)) begin
            state_q   <= ST_IDLE;
            done_o    <= 1'b1;
            timeout_o <= 1'b0;
            crc_err_o <= (crc_nxt != 4'd0);
            id_o      <= hdr_q[3:2];
            tag_o     <= hdr_q[1:0];
            rdata_o   <= (hdr_q[1:0] == TAG_ACK) ? unpacked : '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(rdata_o) && $stable(tag_o) && $stable(id_o))); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(timeout_o && crc_err_o)); // R4
  AST_TIMEOUT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (rdata_o == '0 && tag_o == 2'd0 && id_o == 2'd0)); // R4
  AST_NACK_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && tag_o != TAG_ACK) |-> (rdata_o == '0)); // R6
  AST_OE_RESTORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (oe_o && bclk_o)); // R3
endmodule

// File: tb/resp_frame_rx_tb.sv
`timescale 1ns/1ps
module resp_frame_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] size = 2'd0;
  logic sdata = 1'b1;
  logic bclk, oe, done, tmo, cerr;
  logic [1:0] tag, id;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;

  logic [63:0] fr;
  int flen, lead, idx;

  always #2 clk = ~clk;

  resp_frame_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .sdata_i(sdata),
    .bclk_o(bclk), .oe_o(oe), .done_o(done), .timeout_o(tmo), .crc_err_o(cerr),
    .tag_o(tag), .id_o(id), .rdata_o(rdata)
  );

  // slave model: next bit on each falling link clock, wire active-low
  initial forever begin
    @(negedge bclk);
    if (idx >= lead && idx < lead + flen) sdata = ~fr[flen - 1 - (idx - lead)];
    else                                  sdata = 1'b1;
    idx++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] crc4(input logic [63:0] v, input int n);
    logic [3:0] c = 4'd0;
    for (int i = n - 1; i >= 0; i--) begin
      logic f = c[3] ^ v[i];
      c = {c[2:0], 1'b0} ^ (f ? 4'b0011 : 4'b0000);
    end
    return c;
  endfunction

  task automatic push(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      fr = {fr[62:0], v[i]};
      flen++;
    end
  endtask

  task automatic setup(input int l, input logic [1:0] i_id, input logic [1:0] i_tag,
                       input int nb, input logic [31:0] d, input bit corrupt);
    logic [3:0] c;
    fr = '0; flen = 0;
    push(8'd1, 1);
    push({6'd0, i_id}, 2);
    push({6'd0, i_tag}, 2);
    for (int k = 0; k < nb; k++) push(d[8*k +: 8], 8);
    c = crc4(fr, flen);
    if (corrupt) c = c ^ 4'b0100;
    push({4'd0, c}, 4);
    lead = l; idx = 0;
  endtask

  // returns number of negedges after the accepting edge until done_o seen
  task automatic run(input logic [1:0] sz, input bit restart, output int cyc);
    @(negedge clk); size = sz; start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    chk(oe == 1'b0, "R3", "oe released", 32'(oe), 32'd0);
    while (!done && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (restart && cyc == 20) start = 1'b1;
      if (restart && cyc == 21) start = 1'b0;
    end
    chk(done == 1'b1, "R9", "done seen", 32'(done), 32'd1);
    chk(oe && bclk, "R3", "oe/bclk restored", {30'd0, oe, bclk}, 32'd3);
  endtask

  task automatic after_done(input logic [31:0] d);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 32'(done), 32'd0);
    chk(rdata == d, "R9", "rdata held", rdata, d);
  endtask

  task automatic t_reset;
    chk(bclk && oe, "R1", "bclk/oe in reset", {30'd0, bclk, oe}, 32'd3);
    chk(!done && !tmo && !cerr, "R1", "flags in reset", {29'd0, done, tmo, cerr}, 32'd0);
    chk(rdata == 0 && tag == 0 && id == 0, "R1", "results in reset", rdata, 32'd0);
  endtask

  task automatic t_read4;
    int c;
    setup(3, 2'd2, 2'd0, 4, 32'h44332211, 1'b0);
    run(2'd3, 1'b0, c);
    chk(rdata == 32'h44332211, "R7", "4-byte order", rdata, 32'h44332211);
    chk(id == 2'd2 && tag == 2'd0, "R5", "id/tag", {28'd0, id, tag}, 32'h8);
    chk(!cerr && !tmo, "R8", "good frame flags", {30'd0, cerr, tmo}, 32'd0);
    // S = 3 lead + 1 + 4 + 32 + 4
    chk(c == 2 * 44 + 1, "R11", "latency 4-byte", c, 32'(2 * 44 + 1));
    after_done(32'h44332211);
  endtask

  task automatic t_read1;
    int c;
    setup(0, 2'd1, 2'd0, 1, 32'h000000A5, 1'b0);
    run(2'd1, 1'b0, c);
    chk(rdata == 32'h000000A5, "R7", "1-byte", rdata, 32'hA5);
    chk(c == 2 * 17 + 1, "R2", "bit period two cycles", c, 32'(35));
  endtask

  task automatic t_read2;
    int c;
    setup(5, 2'd3, 2'd0, 2, 32'h0000C35A, 1'b0);
    run(2'd2, 1'b0, c);
    chk(rdata == 32'h0000C35A, "R7", "2-byte", rdata, 32'hC35A);
    chk(id == 2'd3, "R5", "id 3", 32'(id), 32'd3);
  endtask

  task automatic t_busy;
    int c;
    setup(2, 2'd1, 2'd1, 0, 32'd0, 1'b0);
    run(2'd3, 1'b0, c);
    chk(tag == 2'd1 && rdata == 0, "R6", "busy skips data", {tag, rdata[29:0]}, 32'h40000000);
    chk(!cerr, "R6", "busy frame check ok", 32'(cerr), 32'd0);
    chk(c == 2 * 11 + 1, "R6", "busy frame length", c, 32'd23);
  endtask

  task automatic t_ack_nosize;
    int c;
    setup(1, 2'd0, 2'd0, 0, 32'd0, 1'b0);
    run(2'd0, 1'b0, c);
    chk(!cerr && tag == 0 && rdata == 0, "R6", "ack no size", {cerr, 29'd0, tag}, 32'd0);
  endtask

  task automatic t_errtag;
    int c;
    setup(0, 2'd2, 2'd3, 0, 32'd0, 1'b0);
    run(2'd1, 1'b0, c);
    chk(tag == 2'd3 && id == 2'd2, "R5", "slave check error tag", {28'd0, id, tag}, 32'hB);
  endtask

  task automatic t_crc_bad;
    int c;
    setup(2, 2'd1, 2'd0, 2, 32'h00001234, 1'b1);
    run(2'd2, 1'b0, c);
    chk(cerr == 1'b1 && !tmo, "R8", "corrupt detected", {30'd0, cerr, tmo}, 32'd2);
    chk(rdata == 32'h00001234, "R8", "data still reported", rdata, 32'h1234);
  endtask

  task automatic t_late_start;
    int c;
    setup(999, 2'd2, 2'd2, 0, 32'd0, 1'b0);
    run(2'd0, 1'b0, c);
    chk(!tmo && tag == 2'd2, "R4", "start in last window bit", {29'd0, tmo, tag}, 32'd2);
  endtask

  task automatic t_timeout;
    int c;
    setup(1000, 2'd1, 2'd0, 1, 32'hFF, 1'b0);
    run(2'd1, 1'b0, c);
    chk(tmo && !cerr, "R4", "timeout flag", {30'd0, tmo, cerr}, 32'd2);
    chk(rdata == 0 && tag == 0 && id == 0, "R4", "timeout results zero", rdata, 32'd0);
    chk(c == 2 * 1000 + 1, "R11", "timeout latency", c, 32'd2001);
  endtask

  task automatic t_restart_ignored;
    int c;
    setup(4, 2'd1, 2'd0, 4, 32'hDEADBEEF, 1'b0);
    run(2'd3, 1'b1, c);
    chk(rdata == 32'hDEADBEEF && !cerr, "R10", "restart ignored data", rdata, 32'hDEADBEEF);
    chk(c == 2 * 45 + 1, "R10", "restart ignored latency", c, 32'd91);
  endtask

  initial begin
    lead = 0; flen = 0; idx = 0; fr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read4();
    t_read1();
    t_read2();
    t_busy();
    t_ack_nosize();
    t_errtag();
    t_crc_bad();
    t_late_start();
    t_timeout();
    t_restart_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule